// File: doc/BRIEF.md
# E3 Transmit Overhead Inserter

This block turns a serial E3 payload stream into outbound frames of 1536 bits, sent one bit per clock. It owns the bit position within the frame. In the overhead slots it writes its own bits, and in every other slot it asks the upstream source for the next payload bit. The overhead is a 10-bit alignment word, an alarm (A) bit, a national (N) bit and, when enabled, a 4-bit parity nibble at the end of the frame. The parity nibble carries the parity of the previous frame.

A three-register write port sets the service-bit values, the A and N source selects, parity insertion and the alignment-word source. It also provides two line overrides: all-ones for alarm indication and all-zeros for loss of signal. Test corruption of the alignment word or of the parity nibble is armed through a one-shot write. Every write waits in a shadow copy and takes effect at the next frame start, so the frame that is on the line when a write arrives is never disturbed.

Top module: `e3_oh_inserter`

## Requirements
- R1: A frame is 1536 clock cycles long. `tx_sof` is high for exactly one cycle, together with the first bit of each frame. While `rst` is high, `tx_bit` and `tx_sof` are 0, and the first frame starts on the cycle after `rst` falls.
- R2: With the alignment-source flag clear (config bit 0 = 0), frame bits 1..10 carry 1111010000, leftmost bit first.
- R3: Bit 11 is the A bit, chosen by config bits 6:5: 00 = service register bit 1, 01 = input `alm_ext_i`, 10 = constant 0, 11 = constant 1. The service register resets to A = 1 and N = 0.
- R4: Bit 12 is the N bit, chosen by config bits 4:3 with the same encoding, using service register bit 0 and input `nat_ext_i`.
- R5: Every payload slot carries the `pay_i` value present in the cycle that `pay_req` is high, and the bit appears on `tx_bit` one cycle later. Payload slots are bits 13..1536, minus the parity nibble when it is enabled. Bits are sent in the order they were taken.
- R6: Config bit 7 enables the parity nibble in bits 1533..1536. When bit 7 is 0, these four bits are payload.
- R7: Parity lane k (k = 0..3) is the XOR of all transmitted frame bits n with (n-1) mod 4 = k. The value computed over one frame is sent in the next frame: lane k goes in bit 1533+k. After reset the carried value is 0.
- R8: With config bit 0 set, bits 1..10 become payload slots: `pay_req` goes high for them and they carry upstream bits.
- R9: Config bit 2 forces every output bit of the frame to 1. Config bit 1 forces every output bit to 0 and takes priority over bit 2. Parity is computed over the forced bits.
- R10: Writing 1 to bit 0 of the inject register (select 2) inverts all ten alignment bits of exactly one frame. Bit 1 inverts the parity nibble of exactly one frame. The armed request is cleared at the frame start where it is applied.
- R11: Writes to config (select 0), service (select 1) or inject (select 2) made during a frame leave that frame unchanged and apply from the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 service bits, 2 inject |
| reg_wdata | input | 8 | Write data |
| alm_ext_i | input | 1 | External alarm value for the A bit |
| nat_ext_i | input | 1 | External value for the N bit |
| pay_i | input | 1 | Upstream payload bit, taken when `pay_req` is high |
| pay_req | output | 1 | Request for an upstream bit in this cycle |
| tx_bit | output | 1 | Serial frame output |
| tx_sof | output | 1 | High with the first bit of each frame |

## Verification
The bench runs a chain of frames with a different control set in each. In every frame it rebuilds the expected line bit by bit, using the parity of the frame it captured just before. A design that put parity into the same frame it was computed over, or that left its own nibble or a corruption out of the sum, fails the nibble comparison on the following frame. The bench writes each new configuration during the frame before the one it applies to. A design that switched at once would alter the frame in progress, which is most visible just before the all-ones frame. One-shot corruption is checked in the frame where it applies and again in the frame after it, so a request that never cleared would corrupt both. The alarm override combined with loss of signal shows whether priority is handled correctly.

// File: rtl/e3ohi_pkg.sv
package e3ohi_pkg;

    localparam int FAS_LEN = 10;
    localparam int FAS_IW  = $clog2(FAS_LEN);
    localparam logic [FAS_LEN-1:0] FAS_WORD = 10'b1111010000;
    localparam int A_SLOT  = 10;
    localparam int N_SLOT  = 11;
    localparam int NIB     = 4;
    localparam int LANE_W  = $clog2(NIB);

    localparam logic [1:0] SEL_CFG = 2'd0;
    localparam logic [1:0] SEL_SVC = 2'd1;
    localparam logic [1:0] SEL_INJ = 2'd2;

    // Config byte: field order sets the bit positions (bip_en is bit 7)
    typedef struct packed {
        logic       bip_en;
        logic [1:0] a_src;
        logic [1:0] n_src;
        logic       ais;
        logic       los;
        logic       fas_ext;
    } tx_cfg_t;

    typedef struct packed {
        logic a_val;
        logic n_val;
    } svc_bits_t;

    typedef struct packed {
        logic bip;
        logic fas;
    } inj_req_t;

    typedef enum logic [2:0] {
        SLOT_FAS,
        SLOT_ALM,
        SLOT_NAT,
        SLOT_BIP,
        SLOT_PAY
    } slot_e;

    localparam tx_cfg_t   CFG_RST = '0;
    localparam svc_bits_t SVC_RST = '{a_val: 1'b1, n_val: 1'b0};

    function automatic logic pick_src(input logic [1:0] sel, input logic reg_v,
                                      input logic ext_v);
        unique case (sel)
            2'b00:   return reg_v;
            2'b01:   return ext_v;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/e3ohi_frame_ctr.sv
module e3ohi_frame_ctr #(
    parameter int FRAME_BITS = 1536,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos,
    output logic             last
);

    assign last = (pos == POS_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || last) pos <= '0;
        else             pos <= pos + 1'b1;
    end

endmodule

// File: rtl/e3ohi_ctrl_regs.sv
module e3ohi_ctrl_regs
    import e3ohi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] sel,
    input  logic [7:0] wdata,
    input  logic       frame_end,
    output tx_cfg_t    act_cfg,
    output svc_bits_t  act_svc,
    output inj_req_t   act_inj,
    output logic [1:0] inj_arm
);

    tx_cfg_t   shd_cfg;
    svc_bits_t shd_svc;
    logic [1:0] arm_set;

    assign arm_set = (wr && sel == SEL_INJ) ? wdata[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cfg <= CFG_RST;
            shd_svc <= SVC_RST;
            act_cfg <= CFG_RST;
            act_svc <= SVC_RST;
            act_inj <= '0;
            inj_arm <= '0;
        end else begin
            if (wr && sel == SEL_CFG) shd_cfg <= tx_cfg_t'(wdata);
            if (wr && sel == SEL_SVC) shd_svc <= svc_bits_t'(wdata[1:0]);
            inj_arm <= (frame_end ? 2'b00 : inj_arm) | arm_set;
            if (frame_end) begin
                act_cfg <= shd_cfg;
                act_svc <= shd_svc;
                act_inj <= inj_req_t'(inj_arm);
            end
        end
    end

endmodule

// File: rtl/e3ohi_bip_acc.sv
module e3ohi_bip_acc
    import e3ohi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_i,
    input  logic [LANE_W-1:0] lane,
    input  logic              frame_end,
    output logic [NIB-1:0]    bip_q
);

    logic [NIB-1:0] acc;
    logic [NIB-1:0] acc_nx;

    for (genvar k = 0; k < NIB; k++) begin : g_lane
        assign acc_nx[k] = acc[k] ^ (bit_i && lane == LANE_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            bip_q <= '0;
        end else if (frame_end) begin
            acc   <= '0;
            bip_q <= acc_nx;
        end else begin
            acc   <= acc_nx;
        end
    end

endmodule

// File: rtl/e3_oh_inserter.sv
module e3_oh_inserter
    import e3ohi_pkg::*;
#(
    parameter int FRAME_BITS = 1536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       alm_ext_i,
    input  logic       nat_ext_i,
    input  logic       pay_i,
    output logic       pay_req,
    output logic       tx_bit,
    output logic       tx_sof
);

    localparam int POS_W     = $clog2(FRAME_BITS);
    localparam int BIP_FIRST = FRAME_BITS - NIB;

    logic [POS_W-1:0]   pos;
    logic               last_bit;
    tx_cfg_t            act_cfg;
    svc_bits_t          act_svc;
    inj_req_t           act_inj;
    logic [1:0]         inj_arm;
    logic [NIB-1:0]     bip_q;
    slot_e              slot;
    logic [FAS_LEN-1:0] fas_sh;
    logic               raw_bit;
    logic               line_bit;
    logic               act_los;
    logic               act_ais;
    logic               inj_wr;

    e3ohi_frame_ctr #(.FRAME_BITS(FRAME_BITS)) i_ctr (
        .clk  (clk),
        .rst  (rst),
        .pos  (pos),
        .last (last_bit)
    );

    e3ohi_ctrl_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .frame_end (last_bit),
        .act_cfg   (act_cfg),
        .act_svc   (act_svc),
        .act_inj   (act_inj),
        .inj_arm   (inj_arm)
    );

    e3ohi_bip_acc i_bip (
        .clk       (clk),
        .rst       (rst),
        .bit_i     (line_bit),
        .lane      (pos[LANE_W-1:0]),
        .frame_end (last_bit),
        .bip_q     (bip_q)
    );

    assign act_los = act_cfg.los;
    assign act_ais = act_cfg.ais;
    assign inj_wr  = reg_wr && (reg_sel == SEL_INJ);

    always_comb begin
        if (pos < POS_W'(FAS_LEN))                             slot = SLOT_FAS;
        else if (pos == POS_W'(A_SLOT))                        slot = SLOT_ALM;
        else if (pos == POS_W'(N_SLOT))                        slot = SLOT_NAT;
        else if (act_cfg.bip_en && pos >= POS_W'(BIP_FIRST))   slot = SLOT_BIP;
        else                                                   slot = SLOT_PAY;
    end

    assign fas_sh  = FAS_WORD << pos[FAS_IW-1:0];
    assign pay_req = (slot == SLOT_PAY) || (slot == SLOT_FAS && act_cfg.fas_ext);

    always_comb begin
        unique case (slot)
            SLOT_FAS: raw_bit = act_cfg.fas_ext ? pay_i
                                                : (fas_sh[FAS_LEN-1] ^ act_inj.fas);
            SLOT_ALM: raw_bit = pick_src(act_cfg.a_src, act_svc.a_val, alm_ext_i);
            SLOT_NAT: raw_bit = pick_src(act_cfg.n_src, act_svc.n_val, nat_ext_i);
            SLOT_BIP: raw_bit = bip_q[pos[LANE_W-1:0]] ^ act_inj.bip;
            default:  raw_bit = pay_i;
        endcase
        if (act_cfg.los)      line_bit = 1'b0;
        else if (act_cfg.ais) line_bit = 1'b1;
        else                  line_bit = raw_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_bit <= 1'b0;
            tx_sof <= 1'b0;
        end else begin
            tx_bit <= line_bit;
            tx_sof <= (pos == '0);
        end
    end

endmodule

// File: rtl/e3ohi_checker.sv
module e3ohi_checker #(
    parameter int FRAME_BITS = 1536
) (
    input logic       clk,
    input logic       rst,
    input logic       tx_sof,
    input logic       tx_bit,
    input logic       act_los,
    input logic       act_ais,
    input logic [1:0] inj_arm,
    input logic       last_bit,
    input logic       inj_wr
);

    int   since_sof;
    logic seen_sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_sof <= 0;
            seen_sof  <= 1'b0;
        end else if (tx_sof) begin
            since_sof <= 0;
            seen_sof  <= 1'b1;
        end else begin
            since_sof <= since_sof + 1;
        end
    end

    AST_SOF_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (tx_sof && seen_sof) |-> since_sof == FRAME_BITS - 1); // R1

    AST_SOF_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (seen_sof && since_sof < FRAME_BITS - 1) |-> !tx_sof); // R1

    AST_LOS_ZEROES: assert property (@(posedge clk) disable iff (rst)
        act_los |=> !tx_bit); // R9

    AST_AIS_ONES: assert property (@(posedge clk) disable iff (rst)
        (act_ais && !act_los) |=> tx_bit); // R9

    AST_INJ_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        (last_bit && !inj_wr) |=> inj_arm == 2'b00); // R10

endmodule

bind e3_oh_inserter e3ohi_checker #(.FRAME_BITS(FRAME_BITS)) i_checker (
    .clk      (clk),
    .rst      (rst),
    .tx_sof   (tx_sof),
    .tx_bit   (tx_bit),
    .act_los  (act_los),
    .act_ais  (act_ais),
    .inj_arm  (inj_arm),
    .last_bit (last_bit),
    .inj_wr   (inj_wr)
);

// File: tb/test_e3_oh_inserter.sv
module test_e3_oh_inserter;

    localparam int FB = 1536;
    localparam int NF = 11;
    localparam logic [9:0] PAT = 10'b1111010000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       alm_ext_i = 1'b0;
    logic       nat_ext_i = 1'b1;
    logic       pay_i = 1'b0;
    logic       pay_req;
    logic       tx_bit;
    logic       tx_sof;

    int checks = 0;
    int errors = 0;
    logic q[$];
    logic fr[FB];
    logic [7:0] cfg_tab[NF+1];
    logic [7:0] svc_tab[NF+1];
    logic [7:0] inj_tab[NF+1];
    logic [3:0] prev_bip = 4'h0;
    bit underflow;

    always #2 clk = ~clk;

    e3_oh_inserter i_e3_oh_inserter (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .alm_ext_i (alm_ext_i),
        .nat_ext_i (nat_ext_i),
        .pay_i     (pay_i),
        .pay_req   (pay_req),
        .tx_bit    (tx_bit),
        .tx_sof    (tx_sof)
    );

    // Upstream source: new random bit each cycle, recorded when requested (R5)
    always @(negedge clk) begin
        pay_i = 1'($urandom);
        if (!rst && pay_req) q.push_back(pay_i);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input logic [1:0] sel, input logic rv, input logic ev);
        case (sel)
            2'b00:   return rv;
            2'b01:   return ev;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic pop_pay();
        if (q.size() == 0) begin
            underflow = 1'b1;
            return 1'b0;
        end
        return q.pop_front();
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check_frame(input int f);
        logic [7:0] c, s, i;
        logic e, ea, en;
        logic [3:0] par;
        int bad_fas, bad_pay, bad_tail, bad_bip, ones;
        string ov, fas_tag, bip_tag;
        c = cfg_tab[f];
        s = svc_tab[f];
        i = inj_tab[f];
        bad_fas = 0; bad_pay = 0; bad_tail = 0; bad_bip = 0; ones = 0;
        par = 4'h0; underflow = 1'b0; ea = 1'b0; en = 1'b0;
        for (int p = 0; p < FB; p++) begin
            if (p < 10)                     e = c[0] ? pop_pay() : (PAT[9-p] ^ i[0]);
            else if (p == 10)               e = pick(c[6:5], s[1], alm_ext_i);
            else if (p == 11)               e = pick(c[4:3], s[0], nat_ext_i);
            else if (c[7] && p >= FB - 4)   e = prev_bip[p%4] ^ i[1];
            else                            e = pop_pay();
            if (c[1])      e = 1'b0;
            else if (c[2]) e = 1'b1;
            if (p == 10) ea = e;
            if (p == 11) en = e;
            if (fr[p] !== e) begin
                if (p < 10)                    bad_fas++;
                else if (p >= FB - 4 && c[7])  bad_bip++;
                else if (p >= FB - 4)          bad_tail++;
                else if (p > 11)               bad_pay++;
            end
            par[p%4] ^= fr[p];
            if (fr[p] === 1'b1) ones++;
        end
        ov = c[1] ? "R9 LOS all-zero" : "R9 AIS all-one";
        if (c[1] || c[2])                   fas_tag = ov;
        else if (i[0])                      fas_tag = "R10 FAS inversion";
        else if (c[0])                      fas_tag = "R8 external FAS";
        else if (f > 0 && inj_tab[f-1][0])  fas_tag = "R10 FAS request cleared";
        else                                fas_tag = "R2 alignment word";
        check(bad_fas == 0, $sformatf("%s frame %0d mismatches", fas_tag, f), bad_fas, 0);
        check(fr[10] === ea, $sformatf("%s frame %0d", (c[1] || c[2]) ? ov : "R3 A bit", f),
              int'(fr[10]), int'(ea));
        check(fr[11] === en, $sformatf("%s frame %0d", (c[1] || c[2]) ? ov : "R4 N bit", f),
              int'(fr[11]), int'(en));
        check(bad_pay == 0 && !underflow,
              $sformatf("R5 payload frame %0d mismatches", f), bad_pay, 0);
        if (c[7]) begin
            if (c[1] || c[2])  bip_tag = ov;
            else if (i[1])     bip_tag = "R10 parity inversion";
            else               bip_tag = "R7 carried parity";
            check(bad_bip == 0, $sformatf("%s frame %0d mismatches", bip_tag, f), bad_bip, 0);
        end else begin
            check(bad_tail == 0, $sformatf("R6 last nibble payload frame %0d mismatches", f),
                  bad_tail, 0);
        end
        if (f + 1 <= NF && cfg_tab[f+1][2] && !c[1] && !c[2])
            check(ones < FB, $sformatf("R11 frame %0d unaffected by pending AIS", f), ones, FB - 1);
        prev_bip = par;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int sof_bad;
        // frame 0 = reset state; later entries are written during the frame before
        cfg_tab[0]  = 8'h00; svc_tab[0]  = 8'h02; inj_tab[0]  = 8'h00;
        cfg_tab[1]  = 8'h80; svc_tab[1]  = 8'h01; inj_tab[1]  = 8'h00;
        cfg_tab[2]  = 8'h80; svc_tab[2]  = 8'h01; inj_tab[2]  = 8'h01;
        cfg_tab[3]  = 8'hB8; svc_tab[3]  = 8'h02; inj_tab[3]  = 8'h00;
        cfg_tab[4]  = 8'hE8; svc_tab[4]  = 8'h00; inj_tab[4]  = 8'h02;
        cfg_tab[5]  = 8'hD0; svc_tab[5]  = 8'h03; inj_tab[5]  = 8'h00;
        cfg_tab[6]  = 8'h81; svc_tab[6]  = 8'h02; inj_tab[6]  = 8'h00;
        cfg_tab[7]  = 8'h84; svc_tab[7]  = 8'h02; inj_tab[7]  = 8'h00;
        cfg_tab[8]  = 8'h86; svc_tab[8]  = 8'h02; inj_tab[8]  = 8'h00;
        cfg_tab[9]  = 8'h80; svc_tab[9]  = 8'h02; inj_tab[9]  = 8'h00;
        cfg_tab[10] = 8'h00; svc_tab[10] = 8'h01; inj_tab[10] = 8'h00;
        cfg_tab[11] = 8'h00; svc_tab[11] = 8'h02; inj_tab[11] = 8'h00;

        repeat (3) @(negedge clk);
        check(tx_bit === 1'b0 && tx_sof === 1'b0, "R1 outputs low in reset",
              int'({tx_bit, tx_sof}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_sof === 1'b1, "R1 first frame starts after reset", int'(tx_sof), 1);

        for (int f = 0; f < NF; f++) begin
            sof_bad = 0;
            for (int idx = 0; idx < FB; idx++) begin
                if (idx > 0) begin
                    @(negedge clk);
                    if (tx_sof !== 1'b0) sof_bad++;
                end
                fr[idx] = tx_bit;
                case (idx)
                    0: begin reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = cfg_tab[f+1]; end
                    1: begin reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = svc_tab[f+1]; end
                    2: begin reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = inj_tab[f+1]; end
                    3: begin reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00; end
                    default: ;
                endcase
            end
            check(sof_bad == 0, $sformatf("R1 no frame marker inside frame %0d", f), sof_bad, 0);
            @(negedge clk);
            check(tx_sof === 1'b1, $sformatf("R1 marker after 1536 bits, frame %0d", f),
                  int'(tx_sof), 1);
            check_frame(f);
        end

        summary();
        $finish;
    end

endmodule